// File: doc/BRIEF.md
# Dual-Clock Frequency Comparator

This block checks whether a clock under test runs at the expected rate relative to a reference clock. Three seeded down counters are used. A base counter and a window counter count on the reference clock, and the window counter starts only once the base counter has reached zero. A test counter counts on the clock under test. The seeds are chosen so that, at the nominal frequency ratio, the test counter empties partway through the window. The measurement passes when the test counter reaches zero after the base counter and before the window counter. Any other order raises a sticky error.

Software loads the three seeds and a control word over a simple write port on the system clock. In continuous mode, each passing measurement reloads all counters and starts again. In single-shot mode, the block waits for the window counter to run out, reports completion and turns itself off. The start level goes into each counter domain through a two-flop synchronizer, and the zero indications come back the same way. A heartbeat from each counter domain feeds a watchdog on the system clock, so a stalled clock also ends in an error.

Top module: `dual_clk_freq_cmp`

## Requirements
- R1: After reset, `active`, `done` and `err` are all 0.
- R2: Writes with `wr_sel` 0 (base seed), 1 (window seed) and 2 (test seed) load the seed only while `active` is 0. While `active` is 1 they have no effect on any measurement.
- R3: A write with `wr_sel` 3 is a control write. Bit 0 enables the block and bit 1 selects single-shot mode (1) or continuous mode (0); the mode is taken only when the block is off. Bit 2 clears the error. An enable is refused while `err` is 1 unless bit 2 is set in the same write. Writing bit 0 as 0 turns the block off.
- R4: On each start, the base and window counters are loaded from their seeds in the reference domain, and the test counter is loaded in the test domain. The window counter decrements only after the base counter has reached zero.
- R5: A measurement passes when the test counter is seen at zero after the base counter is at zero and no later than the window counter reaching zero.
- R6: If the test counter reaches zero while the base counter is non-zero, `err` is set, `done` is cleared and `active` drops to 0.
- R7: If the window counter reaches zero while the test counter is non-zero, `err` is set and `active` drops to 0.
- R8: In single-shot mode, a pass completes only once the window counter has also reached zero. At that point `done` goes to 1 and `active` clears by itself.
- R9: In continuous mode, every pass sets `done` and restarts with fresh seed values. `active` stays 1.
- R10: `err` holds until a control write with bit 2 set. `done` and `err` are never 1 together.
- R11: If either counter clock shows no activity for `WD_LIMIT` system cycles while a measurement is in progress, `err` is set and `active` drops to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock for the write port, the controller and the watchdog |
| sys_rst_n | input | 1 | Active-low asynchronous reset; released synchronously in each domain |
| ref_clk | input | 1 | Reference clock driving the base and window counters |
| tst_clk | input | 1 | Clock under test driving the test counter |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 base seed, 1 window seed, 2 test seed, 3 control |
| wr_data | input | SEED_W | Seed value, or control bits {clear, single, enable} in bits 2..0 |
| active | output | 1 | Block enabled and measuring |
| done | output | 1 | A measurement has passed (sticky until the next enable) |
| err | output | 1 | A measurement failed or a clock stalled (sticky) |

## Verification
A zero indication takes one domain register plus two system-clock flops to reach the controller, and one more system edge to reach `done` or `err`. A start takes two flops and one load edge in each counter domain. That gives a few hundred nanoseconds of timing uncertainty around every counter expiry. The bench's reference model therefore classifies each seed set with a 300 ns guard band and uses only seed sets that fall clearly into one class. It then waits for `active` to fall, or for a fixed span of several measurement periods, before it compares. The single-shot tail is sampled 100 ns before the window expires, and the watchdog result is sampled before any counter-based error could occur.

// File: rtl/dual_clk_freq_cmp.sv
`timescale 1ns/1ps
module dual_clk_freq_cmp #(
  parameter int SEED_W   = 20,
  parameter int WD_LIMIT = 200,
  parameter int HB_BIT   = 1
) (
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              ref_clk,
  input  logic              tst_clk,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [SEED_W-1:0] wr_data,
  output logic              active,
  output logic              done,
  output logic              err
);
  localparam int              WD_W   = $clog2(WD_LIMIT + 1);
  localparam logic [WD_W-1:0] WD_MAX = WD_W'(WD_LIMIT);
  localparam logic [SEED_W-1:0] ONE  = SEED_W'(1);
  localparam logic [HB_BIT:0] HB_ONE = (HB_BIT+1)'(1);
  localparam logic [1:0] SEL_REF = 2'd0, SEL_WIN = 2'd1, SEL_TST = 2'd2, SEL_CTL = 2'd3;

  typedef enum logic [2:0] {PH_IDLE, PH_SETTLE, PH_ARM, PH_RUN, PH_TAIL} phase_t;

  logic [SEED_W-1:0] seed_ref, seed_win, seed_tst;
  logic              en_q, ss_q, done_q, err_q, go_q;
  phase_t            phase, ph_d;

  // reset release per counter domain
  logic [1:0] r_rst_sh, t_rst_sh;
  logic       r_rst_n, t_rst_n;
  always_ff @(posedge ref_clk or negedge sys_rst_n)
    if (!sys_rst_n) r_rst_sh <= '0;
    else            r_rst_sh <= {r_rst_sh[0], 1'b1};
  always_ff @(posedge tst_clk or negedge sys_rst_n)
    if (!sys_rst_n) t_rst_sh <= '0;
    else            t_rst_sh <= {t_rst_sh[0], 1'b1};
  assign r_rst_n = r_rst_sh[1];
  assign t_rst_n = t_rst_sh[1];

  // reference domain: base counter then window counter
  logic [1:0]        r_go_sh;
  logic              r_armed, r_z0, r_zv;
  logic [SEED_W-1:0] c0_q, v_q;
  logic [HB_BIT:0]   r_hb_cnt;

  always_ff @(posedge ref_clk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      r_go_sh  <= '0;
      r_armed  <= 1'b0;
      r_z0     <= 1'b0;
      r_zv     <= 1'b0;
      c0_q     <= '0;
      v_q      <= '0;
      r_hb_cnt <= '0;
    end else begin
      r_go_sh  <= {r_go_sh[0], go_q};
      r_hb_cnt <= r_hb_cnt + HB_ONE;
      if (!r_go_sh[1]) r_armed <= 1'b0;
      else if (!r_armed) begin
        r_armed <= 1'b1;
        c0_q    <= seed_ref;
        v_q     <= seed_win;
      end
      else if (c0_q != '0) c0_q <= c0_q - ONE;
      else if (v_q != '0)  v_q  <= v_q - ONE;
      r_z0 <= r_armed && r_go_sh[1] && (c0_q == '0);
      r_zv <= r_armed && r_go_sh[1] && (c0_q == '0) && (v_q == '0);
    end
  end

  AST_WINDOW_WAITS: assert property (@(posedge ref_clk) disable iff (!r_rst_n) (r_armed && c0_q != '0) |=> (v_q == $past(v_q))); // R4

  // test domain
  logic [1:0]        t_go_sh;
  logic              t_armed, t_z1;
  logic [SEED_W-1:0] c1_q;
  logic [HB_BIT:0]   t_hb_cnt;

  always_ff @(posedge tst_clk or negedge t_rst_n) begin
    if (!t_rst_n) begin
      t_go_sh  <= '0;
      t_armed  <= 1'b0;
      t_z1     <= 1'b0;
      c1_q     <= '0;
      t_hb_cnt <= '0;
    end else begin
      t_go_sh  <= {t_go_sh[0], go_q};
      t_hb_cnt <= t_hb_cnt + HB_ONE;
      if (!t_go_sh[1]) t_armed <= 1'b0;
      else if (!t_armed) begin
        t_armed <= 1'b1;
        c1_q    <= seed_tst;
      end
      else if (c1_q != '0) c1_q <= c1_q - ONE;
      t_z1 <= t_armed && t_go_sh[1] && (c1_q == '0);
    end
  end

  // return path into the system domain
  logic [6:0] x_in, x_m, x_q;
  logic [1:0] hb_prev;
  assign x_in = {t_hb_cnt[HB_BIT], t_z1, t_armed, r_hb_cnt[HB_BIT], r_zv, r_z0, r_armed};

  logic r_arm_s, z0_s, zv_s, t_arm_s, z1_s, r_hb_ev, t_hb_ev;
  assign r_arm_s = x_q[0];
  assign z0_s    = x_q[1];
  assign zv_s    = x_q[2];
  assign t_arm_s = x_q[4];
  assign z1_s    = x_q[5];
  assign r_hb_ev = x_q[3] ^ hb_prev[0];
  assign t_hb_ev = x_q[6] ^ hb_prev[1];

  logic [WD_W-1:0] wd_r, wd_t;
  logic            wd_trip;
  assign wd_trip = (wd_r == WD_MAX) || (wd_t == WD_MAX);

  // control decode
  logic ctl_wr, clr_req, en_req, dis_req, seed_ok;
  assign ctl_wr  = wr_en && (wr_sel == SEL_CTL);
  assign clr_req = ctl_wr && wr_data[2];
  assign en_req  = ctl_wr && wr_data[0] && (!err_q || wr_data[2]);
  assign dis_req = ctl_wr && !wr_data[0];
  assign seed_ok = wr_en && !en_q;

  logic pass_ev, fail_ev, fin_ev;
  always_comb begin
    ph_d    = phase;
    pass_ev = 1'b0;
    fail_ev = 1'b0;
    fin_ev  = 1'b0;
    case (phase)
      PH_IDLE:   if (en_q) ph_d = PH_SETTLE;
      PH_SETTLE: if (!r_arm_s && !t_arm_s) ph_d = PH_ARM;
      PH_ARM:    if (r_arm_s && t_arm_s) ph_d = PH_RUN;
      PH_RUN: begin
        if (z1_s && !z0_s) fail_ev = 1'b1;
        else if (z1_s) begin
          pass_ev = 1'b1;
          ph_d    = ss_q ? PH_TAIL : PH_SETTLE;
        end
        else if (zv_s) fail_ev = 1'b1;
      end
      PH_TAIL: if (zv_s) begin
        fin_ev = 1'b1;
        ph_d   = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
    if (phase != PH_IDLE && wd_trip) fail_ev = 1'b1;
    if (fail_ev || !en_q) ph_d = PH_IDLE;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      x_m      <= '0;
      x_q      <= '0;
      hb_prev  <= '0;
      wd_r     <= '0;
      wd_t     <= '0;
      phase    <= PH_IDLE;
      go_q     <= 1'b0;
      seed_ref <= '0;
      seed_win <= '0;
      seed_tst <= '0;
      en_q     <= 1'b0;
      ss_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      x_m     <= x_in;
      x_q     <= x_m;
      hb_prev <= {x_q[6], x_q[3]};
      if (phase == PH_IDLE || r_hb_ev) wd_r <= '0;
      else if (wd_r != WD_MAX)         wd_r <= wd_r + 1'b1;
      if (phase == PH_IDLE || t_hb_ev) wd_t <= '0;
      else if (wd_t != WD_MAX)         wd_t <= wd_t + 1'b1;
      phase <= ph_d;
      go_q  <= (ph_d == PH_ARM) || (ph_d == PH_RUN) || (ph_d == PH_TAIL);
      if (seed_ok && wr_sel == SEL_REF) seed_ref <= wr_data;
      if (seed_ok && wr_sel == SEL_WIN) seed_win <= wr_data;
      if (seed_ok && wr_sel == SEL_TST) seed_tst <= wr_data;
      if (fail_ev) begin
        err_q  <= 1'b1;
        done_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        if (clr_req) err_q <= 1'b0;
        if (pass_ev && !ss_q) done_q <= 1'b1;
        if (fin_ev) begin
          done_q <= 1'b1;
          en_q   <= 1'b0;
        end
        else if (en_req && !en_q) begin
          en_q   <= 1'b1;
          ss_q   <= wr_data[1];
          done_q <= 1'b0;
        end
        else if (dis_req) en_q <= 1'b0;
      end
    end
  end

  assign active = en_q;
  assign done   = done_q;
  assign err    = err_q;

  AST_SEED_LOCK: assert property (@(posedge sys_clk) disable iff (!sys_rst_n) en_q |=> $stable({seed_ref, seed_win, seed_tst})); // R2
  AST_ERR_HALTS: assert property (@(posedge sys_clk) disable iff (!sys_rst_n) $rose(err_q) |-> !en_q); // R6
  AST_ERR_STICKY: assert property (@(posedge sys_clk) disable iff (!sys_rst_n) (err_q && !clr_req) |=> err_q); // R10
  AST_NOT_BOTH: assert property (@(posedge sys_clk) disable iff (!sys_rst_n) !(done_q && err_q)); // R10
  AST_SINGLE_OFF: assert property (@(posedge sys_clk) disable iff (!sys_rst_n) ($rose(done_q) && ss_q) |-> !en_q); // R8
  AST_WD_BOUND: assert property (@(posedge sys_clk) disable iff (!sys_rst_n) (wd_trip && phase != PH_IDLE) |=> !en_q); // R11
endmodule

// File: tb/dual_clk_freq_cmp_test.sv
`timescale 1ns/1ps
module dual_clk_freq_cmp_test;
  localparam int SW   = 20;
  localparam int TP0  = 50;
  localparam int TP1  = 20;
  localparam int GB   = 300;
  localparam int C_PASS = 0, C_EARLY = 1, C_LATE = 2, C_AMB = 3;

  logic sys_clk = 1'b0, ref_clk = 1'b0, tst_clk = 1'b0;
  logic ref_run = 1'b1, tst_run = 1'b1;
  logic sys_rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [SW-1:0] wr_data = '0;
  logic active, done, err;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 sys_clk = ~sys_clk;
  always begin #(TP0/2); if (ref_run) ref_clk = ~ref_clk; end
  always begin #(TP1/2); if (tst_run) tst_clk = ~tst_clk; end

  dual_clk_freq_cmp #(.SEED_W(SW), .WD_LIMIT(200), .HB_BIT(1)) uut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .ref_clk(ref_clk), .tst_clk(tst_clk),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .active(active), .done(done), .err(err));

  function automatic int classify(int c0, int v, int c1);
    int t1, t0, tv;
    t1 = c1 * TP1; t0 = c0 * TP0; tv = (c0 + v) * TP0;
    if (t1 < t0 - GB) return C_EARLY;
    if (t1 > t0 + GB && t1 < tv - GB) return C_PASS;
    if (t1 > tv + GB) return C_LATE;
    return C_AMB;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int data);
    @(negedge sys_clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = SW'(data);
    @(negedge sys_clk);
    wr_en = 1'b0;
  endtask

  task automatic seeds(int c0, int v, int c1);
    wr(2'd0, c0); wr(2'd1, v); wr(2'd2, c1);
  endtask

  task automatic wait_idle(string req, int limit);
    int k;
    for (k = 0; k < limit; k++) begin
      @(negedge sys_clk);
      if (!active) break;
    end
    if (k == limit) check({req, " timeout"}, 1, 0);
  endtask

  task automatic single(string req, int c0, int v, int c1);
    int cls;
    cls = classify(c0, v, c1);
    seeds(c0, v, c1);
    wr(2'd3, 3);
    wait_idle(req, 4000);
    check({req, " done"}, int'(done), int'(cls == C_PASS));
    check({req, " err"}, int'(err), int'(cls != C_PASS));
    if (err) wr(2'd3, 4);
  endtask

  initial begin
    #900000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0, v, c1, kind, lo, hi, t0, tv, cls;
    void'($urandom(32'd2024));
    repeat (4) @(negedge sys_clk);
    sys_rst_n = 1'b1;
    repeat (8) @(negedge sys_clk);
    check("R1 active", int'(active), 0);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);

    // directed single-shot cases
    single("R5 pass", 30, 20, 100);
    single("R6 early", 30, 20, 40);
    single("R7 late", 30, 20, 160);

    // R8: pass must wait for the window to run out
    seeds(30, 20, 100);
    wr(2'd3, 3);
    #(2500 - 100);
    @(negedge sys_clk);
    check("R8 tail done", int'(done), 0);
    check("R8 tail active", int'(active), 1);
    wait_idle("R8", 4000);
    check("R8 final done", int'(done), 1);
    check("R8 self off", int'(active), 0);

    // constrained random single-shot runs (R4 loads fresh seeds each time)
    for (int i = 0; i < 24; i++) begin
      c0 = 20 + int'($urandom % 31);
      v  = 16 + int'($urandom % 15);
      kind = int'($urandom % 3);
      t0 = c0 * TP0; tv = (c0 + v) * TP0;
      if (kind == C_PASS) begin
        lo = (t0 + GB) / TP1 + 1; hi = (tv - GB) / TP1 - 1;
      end else if (kind == C_EARLY) begin
        lo = 5; hi = (t0 - GB) / TP1 - 1;
      end else begin
        lo = (tv + GB) / TP1 + 1; hi = lo + 40;
      end
      c1 = lo + int'($urandom % (hi - lo + 1));
      cls = classify(c0, v, c1);
      check("R4 model class", cls, kind);
      single("R4 random", c0, v, c1);
    end

    // R9 continuous pass keeps running; R2 seed write while active ignored
    seeds(30, 20, 100);
    wr(2'd3, 1);
    #15000;
    @(negedge sys_clk);
    check("R9 active", int'(active), 1);
    check("R9 done", int'(done), 1);
    check("R9 err", int'(err), 0);
    wr(2'd2, 10);
    #6000;
    @(negedge sys_clk);
    check("R2 locked err", int'(err), 0);
    check("R2 locked active", int'(active), 1);
    wr(2'd3, 0);
    repeat (3) @(negedge sys_clk);
    check("R3 disable", int'(active), 0);
    single("R2 seeds kept", 30, 20, 100);

    // R6 in continuous mode halts; R10 error holds
    seeds(30, 20, 10);
    wr(2'd3, 1);
    wait_idle("R6 cont", 4000);
    check("R6 cont err", int'(err), 1);
    check("R10 done clear", int'(done), 0);
    #3000;
    @(negedge sys_clk);
    check("R10 hold", int'(err), 1);
    wr(2'd3, 1);
    repeat (4) @(negedge sys_clk);
    check("R3 refuse enable", int'(active), 0);
    wr(2'd3, 4);
    check("R10 cleared", int'(err), 0);

    // R11 watchdog on a stopped test clock, then a stopped reference clock
    seeds(60, 30, 200);
    wr(2'd3, 1);
    #300; tst_run = 1'b0;
    #2200;
    @(negedge sys_clk);
    check("R11 test stall err", int'(err), 1);
    check("R11 test stall active", int'(active), 0);
    tst_run = 1'b1;
    wr(2'd3, 4);
    #500;
    wr(2'd3, 1);
    #300; ref_run = 1'b0;
    #2200;
    @(negedge sys_clk);
    check("R11 ref stall err", int'(err), 1);
    ref_run = 1'b1;
    wr(2'd3, 4);
    #500;
    single("R3 after clear", 30, 20, 100);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule